// File: doc/BRIEF.md
# Dual-Mask Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines and drives two processor interrupt outputs: a normal request and a fast request. Each output has its own enable mask. A mask changes only through two write registers: one that sets the bits written as 1 and one that clears the bits written as 1. Software can also force line 0 high through a sticky flag that it sets and clears with its own pair of registers.

Software reaches the block over a small register bus. The address is a word index. There are separate read and write strobes, and read data is combinational. Reads return the masked status of each output, the raw line levels and the two masks. A child controller in a cascade is simply one of the input lines.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset, both enable masks and the software flag are zero and both outputs are low.
- R2: `irq_out` equals the OR-reduction of (raw level AND normal mask), registered one clock after the inputs or the mask change.
- R3: `fiq_out` equals the OR-reduction of (raw level AND fast mask), with the same one-clock timing.
- R4: A write to word 2 ORs the data into the normal mask. A write to word 3 clears every normal mask bit written as 1. A read of word 2 returns the normal mask.
- R5: A write to word 10 ORs the data into the fast mask. A write to word 11 clears every fast mask bit written as 1. A read of word 10 returns the fast mask.
- R6: A read of word 0 returns raw AND normal mask. A read of word 8 returns raw AND fast mask. A read of word 1 or word 9 returns the raw level.
- R7: Raw bit 0 is input line 0 OR the software flag. Writing 1 in bit 0 of word 4 sets the flag, and writing 1 in bit 0 of word 5 clears it. A write with bit 0 at 0 leaves the flag unchanged, and all other data bits are ignored.
- R8: A read of word 4 returns raw bit 0 in bit 0 and zero in every other bit.
- R9: Writes to words 0, 1, 8, 9 and to any unlisted word change nothing. Reads of words 3, 5, 11 and of unlisted words return zero, and read data is zero while the read strobe is low.
- R10: A line that is high while its mask bit is clear produces no output. The output rises one clock after the mask bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Level-sensitive interrupt lines |
| bus_addr | input | 4 | Word index of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
Read data depends only on the current state and the inputs, so the bench samples it in the same half cycle in which the read strobe is raised. A mask or flag write takes effect at the clock edge of the strobe, which means an output that depends on that write is due one edge later. Both outputs are therefore compared one full clock after each stimulus settles, on the falling edge. A change on the input lines alone shows on the outputs at the next rising edge, and the bench checks it at the falling edge after that.

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  irq_lines,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_out,
  output logic          fiq_out
);
  localparam logic [AW-1:0] A_IRQ_STAT = AW'(0);
  localparam logic [AW-1:0] A_IRQ_RAW  = AW'(1);
  localparam logic [AW-1:0] A_IRQ_SET  = AW'(2);
  localparam logic [AW-1:0] A_IRQ_CLR  = AW'(3);
  localparam logic [AW-1:0] A_SW_SET   = AW'(4);
  localparam logic [AW-1:0] A_SW_CLR   = AW'(5);
  localparam logic [AW-1:0] A_FIQ_STAT = AW'(8);
  localparam logic [AW-1:0] A_FIQ_RAW  = AW'(9);
  localparam logic [AW-1:0] A_FIQ_SET  = AW'(10);
  localparam logic [AW-1:0] A_FIQ_CLR  = AW'(11);

  logic [W-1:0] irq_en, fiq_en, raw;
  logic         soft_q;

  assign raw = irq_lines | {{(W-1){1'b0}}, soft_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= '0;
      fiq_en <= '0;
      soft_q <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_IRQ_SET: irq_en <= irq_en | bus_wdata;
        A_IRQ_CLR: irq_en <= irq_en & ~bus_wdata;
        A_FIQ_SET: fiq_en <= fiq_en | bus_wdata;
        A_FIQ_CLR: fiq_en <= fiq_en & ~bus_wdata;
        A_SW_SET:  if (bus_wdata[0]) soft_q <= 1'b1;
        A_SW_CLR:  if (bus_wdata[0]) soft_q <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
      fiq_out <= 1'b0;
    end else begin
      irq_out <= |(raw & irq_en);
      fiq_out <= |(raw & fiq_en);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_IRQ_STAT: bus_rdata = raw & irq_en;
        A_IRQ_RAW:  bus_rdata = raw;
        A_IRQ_SET:  bus_rdata = irq_en;
        A_SW_SET:   bus_rdata = {{(W-1){1'b0}}, raw[0]};
        A_FIQ_STAT: bus_rdata = raw & fiq_en;
        A_FIQ_RAW:  bus_rdata = raw;
        A_FIQ_SET:  bus_rdata = fiq_en;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

module irq_mask_ctrl_chk #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  irq_lines,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic          irq_out,
  input logic          fiq_out,
  input logic [W-1:0]  irq_en,
  input logic [W-1:0]  fiq_en,
  input logic          soft_q
);
  logic         seen;
  logic         exp_irq, exp_fiq;
  logic [W-1:0] raw_c;
  assign raw_c = irq_lines | {{(W-1){1'b0}}, soft_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      exp_irq <= 1'b0;
      exp_fiq <= 1'b0;
    end else begin
      seen    <= 1'b1;
      exp_irq <= (raw_c & irq_en) != '0;
      exp_fiq <= (raw_c & fiq_en) != '0;
    end
  end

  a_r2_irq_timing: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> irq_out == exp_irq);
  a_r3_fiq_timing: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> fiq_out == exp_fiq);
  a_r4_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(2)) |=> (irq_en & $past(bus_wdata)) == $past(bus_wdata));
  a_r4_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(3)) |=> (irq_en & $past(bus_wdata)) == '0);
  a_r5_fiq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(10)) |=> (fiq_en & $past(bus_wdata)) == $past(bus_wdata));
  a_r5_fiq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(11)) |=> (fiq_en & $past(bus_wdata)) == '0);
  a_r7_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(5) && bus_wdata[0]) |=> !soft_q);
  a_r7_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_wdata[0]) |=> $stable(soft_q));
  a_r9_irq_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != AW'(2) && bus_addr != AW'(3)) |=> $stable(irq_en));
  a_r9_fiq_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != AW'(10) && bus_addr != AW'(11)) |=> $stable(fiq_en));
  a_r9_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out),
  .irq_en(irq_en), .fiq_en(fiq_en), .soft_q(soft_q)
);

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_irq = '0, m_fiq = '0;
  logic        m_sw = 1'b0;

  always #2.5 clk = ~clk;

  irq_mask_ctrl u_dut (.*);

  function automatic logic [31:0] raw_f();
    return irq_lines | {31'b0, m_sw};
  endfunction

  function automatic logic [31:0] rd_f(input logic [3:0] a);
    case (a)
      4'd0:  return raw_f() & m_irq;
      4'd1:  return raw_f();
      4'd2:  return m_irq;
      4'd4:  return {31'b0, raw_f() & 32'h1};
      4'd8:  return raw_f() & m_fiq;
      4'd9:  return raw_f();
      4'd10: return m_fiq;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    case (a)
      4'd2:  m_irq = m_irq | d;
      4'd3:  m_irq = m_irq & ~d;
      4'd10: m_fiq = m_fiq | d;
      4'd11: m_fiq = m_fiq & ~d;
      4'd4:  if (d[0]) m_sw = 1'b1;
      4'd5:  if (d[0]) m_sw = 1'b0;
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 check(tag, bus_rdata, rd_f(a));
    bus_rd = 1'b0;
    #0.5 check("R9 idle read data", bus_rdata, '0);
  endtask

  task automatic out_check(input string tag);
    @(posedge clk);
    @(negedge clk);
    check({tag, " irq R2"}, {31'b0, irq_out}, {31'b0, |(raw_f() & m_irq)});
    check({tag, " fiq R3"}, {31'b0, fiq_out}, {31'b0, |(raw_f() & m_fiq)});
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check("R1 irq_out after reset", {31'b0, irq_out}, '0);
    check("R1 fiq_out after reset", {31'b0, fiq_out}, '0);
    rst_n = 1'b1;
    rd("R1 irq mask reset", 4'd2);
    rd("R1 fiq mask reset", 4'd10);
    rd("R1 soft flag reset", 4'd4);

    irq_lines = 32'h20;
    out_check("R10 masked line");
    check("R10 no output while mask clear", {31'b0, irq_out}, '0);
    wr(4'd2, 32'h20);
    check("R10 not yet at write edge", {31'b0, irq_out}, '0);
    out_check("R10 after mask set");
    check("R10 output rose", {31'b0, irq_out}, 32'h1);
    rd("R6 irq status", 4'd0);
    rd("R6 raw", 4'd1);

    wr(4'd10, 32'h30);
    out_check("R5 fiq set");
    rd("R5 fiq mask", 4'd10);
    rd("R6 fiq status", 4'd8);
    wr(4'd11, 32'h10);
    rd("R5 fiq clear", 4'd10);
    wr(4'd3, 32'hffffffff);
    rd("R4 irq clear all", 4'd2);
    out_check("R4 after clear");

    irq_lines = '0;
    wr(4'd2, 32'h1);
    wr(4'd4, 32'hfffffffe);
    rd("R7 bit0 zero ignored", 4'd1);
    wr(4'd4, 32'h1);
    rd("R7 soft set raw", 4'd1);
    rd("R8 soft readback", 4'd4);
    out_check("R7 soft drives irq");
    wr(4'd5, 32'hfffffffe);
    rd("R7 clear bit0 zero ignored", 4'd4);
    wr(4'd5, 32'h1);
    rd("R7 soft cleared", 4'd4);
    irq_lines = 32'h1;
    rd("R7 ext line0 raw", 4'd1);
    out_check("R7 ext line0");

    wr(4'd0, 32'hffffffff);
    wr(4'd1, 32'hffffffff);
    wr(4'd9, 32'hffffffff);
    wr(4'd14, 32'hffffffff);
    rd("R9 irq mask untouched", 4'd2);
    rd("R9 fiq mask untouched", 4'd10);
    rd("R9 write-only read", 4'd3);
    rd("R9 write-only read", 4'd11);
    rd("R9 unlisted read", 4'd15);

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 3);
      if (op == 0) begin
        @(negedge clk);
        irq_lines = $urandom;
        out_check("R2 R3 random lines");
      end else if (op == 1) begin
        wr(4'($urandom_range(0, 15)), $urandom);
        out_check("R4 R5 R9 random write");
      end else begin
        rd("R6 R8 R9 random read", 4'($urandom_range(0, 15)));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule